// File: doc/BRIEF.md
# Single-Step Shift Register with Carry Capture

This block is a word-wide register paired with a one-bit carry flop. On each rising clock edge it either holds, takes a new parallel word, or moves its contents one bit position: arithmetic right shift, logical right shift, left shift, or rotate right. Every operation completes on the same edge that samples the request. The carry flop records the bit that leaves the word during a shift, and it keeps its value during a hold or a parallel load.

Five operation requests arrive as separate input lines. A fixed-priority arbiter reduces them to a single granted operation. The granted operation then sets a source select for every bit, the serial value that enters the top bit, and the next carry. A datapath uses the block as its shifter stage by raising one request for one cycle and reading the word and carry on the following cycle.

Top module: `shreg_unit`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros and `carry` is 0. This holds asynchronously, and the values remain at the first edge after release.
- R2: At an edge where no request is high, `q` and `carry` keep their values.
- R3: At an edge where `op_load` is high, `q` takes `din` and `carry` is unchanged.
- R4: Arithmetic right shift (`op_asr`) makes `q` become {q[W-1], q[W-1:1]}, so the top bit is kept, and `carry` becomes the old q[0].
- R5: Logical right shift (`op_lsr`) makes `q` become {0, q[W-1:1]}, and `carry` becomes the old q[0].
- R6: Left shift (`op_shl`) makes `q` become {q[W-2:0], 0}, and `carry` becomes the old q[W-1].
- R7: Rotate right (`op_ror`) makes `q` become {q[0], q[W-1:1]}, and `carry` becomes the old q[0].
- R8: When several requests are high at once, exactly one acts. Priority from highest to lowest is load, arithmetic right, logical right, left, rotate right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_load | input | 1 | Request: parallel load from `din` |
| op_asr | input | 1 | Request: arithmetic shift right by one |
| op_lsr | input | 1 | Request: logical shift right by one |
| op_shl | input | 1 | Request: shift left by one |
| op_ror | input | 1 | Request: rotate right by one |
| din | input | WIDTH (16) | Parallel load word |
| q | output | WIDTH (16) | Register contents |
| carry | output | 1 | Carry flop contents |

## Verification
A wrong per-bit select or a wrong serial fill appears in `q` on the cycle right after the edge that applies the operation. The bench therefore compares the word and carry on every cycle, so such a fault cannot hide behind later steps. A carry captured from the wrong end, or a carry that should have held but changed, appears at once in `carry` and also in the next expected state. Priority faults only show when the competing operations disagree. For that reason the stimulus sets up top bits and bottom bits that separate load, arithmetic, logical, left and rotate results.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  localparam int GRANT_W = 5;
  localparam int G_LOAD  = 0;
  localparam int G_ASR   = 1;
  localparam int G_LSR   = 2;
  localparam int G_SHL   = 3;
  localparam int G_ROR   = 4;

  typedef logic [GRANT_W-1:0] grant_t;

  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_UPPER = 2'd2,
    SRC_LOWER = 2'd3
  } src_e;

  // fixed priority: lowest index wins
  function automatic grant_t arbitrate(grant_t req);
    return req & (~req + grant_t'(1));
  endfunction

  function automatic src_e bit_source(grant_t g);
    if (g[G_LOAD])                         return SRC_LOAD;
    else if (g[G_ASR] | g[G_LSR] | g[G_ROR]) return SRC_UPPER;
    else if (g[G_SHL])                     return SRC_LOWER;
    else                                   return SRC_KEEP;
  endfunction

  function automatic logic msb_feed(grant_t g, logic msb, logic lsb);
    if (g[G_ASR])      return msb;
    else if (g[G_ROR]) return lsb;
    else               return 1'b0;
  endfunction

  function automatic logic carry_feed(grant_t g, logic msb, logic lsb, logic cur);
    if (g[G_SHL])                            return msb;
    else if (g[G_ASR] | g[G_LSR] | g[G_ROR]) return lsb;
    else                                     return cur;
  endfunction

endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
(
  input  grant_t req,
  input  logic   msb,
  input  logic   lsb,
  input  logic   carry_q,
  output grant_t grant,
  output src_e   src,
  output logic   msb_fill,
  output logic   lsb_fill,
  output logic   carry_d
);

  always_comb begin
    grant    = arbitrate(req);
    src      = bit_source(grant);
    msb_fill = msb_feed(grant, msb, lsb);
    lsb_fill = 1'b0;
    carry_d  = carry_feed(grant, msb, lsb, carry_q);
  end

endmodule

// File: rtl/shreg_bit.sv
module shreg_bit
  import shreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic load_bit,
  input  logic upper_bit,
  input  logic lower_bit,
  output logic q
);

  logic d;

  always_comb begin
    unique case (src)
      SRC_LOAD:  d = load_bit;
      SRC_UPPER: d = upper_bit;
      SRC_LOWER: d = lower_bit;
      default:   d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/shreg_carry.sv
module shreg_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/shreg_unit.sv
module shreg_unit
  import shreg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_load,
  input  logic             op_asr,
  input  logic             op_lsr,
  input  logic             op_shl,
  input  logic             op_ror,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  localparam int TOP = WIDTH - 1;

  grant_t req_vec;
  grant_t grant_vec;
  src_e   bit_src;
  logic   msb_fill;
  logic   lsb_fill;
  logic   carry_next;

  always_comb begin
    req_vec         = '0;
    req_vec[G_LOAD] = op_load;
    req_vec[G_ASR]  = op_asr;
    req_vec[G_LSR]  = op_lsr;
    req_vec[G_SHL]  = op_shl;
    req_vec[G_ROR]  = op_ror;
  end

  shreg_ctrl u_ctrl (
    .req      (req_vec),
    .msb      (q[TOP]),
    .lsb      (q[0]),
    .carry_q  (carry),
    .grant    (grant_vec),
    .src      (bit_src),
    .msb_fill (msb_fill),
    .lsb_fill (lsb_fill),
    .carry_d  (carry_next)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic upper_in;
    logic lower_in;
    if (i == TOP) begin : g_top
      assign upper_in = msb_fill;
    end else begin : g_mid_up
      assign upper_in = q[i+1];
    end
    if (i == 0) begin : g_bot
      assign lower_in = lsb_fill;
    end else begin : g_mid_dn
      assign lower_in = q[i-1];
    end
    shreg_bit u_bit (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (bit_src),
      .load_bit  (din[i]),
      .upper_bit (upper_in),
      .lower_bit (lower_in),
      .q         (q[i])
    );
  end

  shreg_carry u_carry (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (carry_next),
    .q     (carry)
  );

endmodule

// File: rtl/shreg_unit_chk.sv
module shreg_unit_chk
  import shreg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_load,
  input logic             op_asr,
  input logic             op_lsr,
  input logic             op_shl,
  input logic             op_ror,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry,
  input grant_t           grant_vec
);

  logic any_req;
  logic do_asr, do_lsr, do_shl, do_ror;

  assign any_req = op_load | op_asr | op_lsr | op_shl | op_ror;
  assign do_asr  = op_asr & ~op_load;
  assign do_lsr  = op_lsr & ~op_load & ~op_asr;
  assign do_shl  = op_shl & ~op_load & ~op_asr & ~op_lsr;
  assign do_ror  = op_ror & ~op_load & ~op_asr & ~op_lsr & ~op_shl;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> (q == $past(q)) && (carry == $past(carry)));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_load |=> (q == $past(din)) && (carry == $past(carry)));

  assert_asr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_asr |=> (q == {$past(q[WIDTH-1]), $past(q[WIDTH-1:1])}) && (carry == $past(q[0])));

  assert_lsr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_lsr |=> (q == {1'b0, $past(q[WIDTH-1:1])}) && (carry == $past(q[0])));

  assert_shl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_shl |=> (q == {$past(q[WIDTH-2:0]), 1'b0}) && (carry == $past(q[WIDTH-1])));

  assert_ror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_ror |=> (q == {$past(q[0]), $past(q[WIDTH-1:1])}) && (carry == $past(q[0])));

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && (any_req == (grant_vec != '0)));

endmodule

bind shreg_unit shreg_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_load   (op_load),
  .op_asr    (op_asr),
  .op_lsr    (op_lsr),
  .op_shl    (op_shl),
  .op_ror    (op_ror),
  .din       (din),
  .q         (q),
  .carry     (carry),
  .grant_vec (grant_vec)
);

// File: tb/tb_shreg_unit.sv
module tb_shreg_unit;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_load = 1'b0, op_asr = 1'b0, op_lsr = 1'b0, op_shl = 1'b0, op_ror = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         carry;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [W-1:0] q;
    logic         c;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] m_q = '0;
  logic         m_c = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shreg_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_load(op_load), .op_asr(op_asr),
    .op_lsr(op_lsr), .op_shl(op_shl), .op_ror(op_ror),
    .din(din), .q(q), .carry(carry)
  );

  task automatic compare(input logic [W-1:0] eq, input logic ec, input string tag);
    n_cmp++;
    if (q !== eq || carry !== ec) begin
      n_bad++;
      $display("FAIL %s: q=%h carry=%b expected q=%h carry=%b", tag, q, carry, eq, ec);
    end
  endtask

  // driver: applies one request set and predicts the outcome
  task automatic step(input logic l, input logic a, input logic r, input logic s,
                      input logic o, input logic [W-1:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    op_load = l; op_asr = a; op_lsr = r; op_shl = s; op_ror = o; din = d;
    if (l)      begin m_q = d; end
    else if (a) begin m_c = m_q[0];   m_q = $signed(m_q) >>> 1; end
    else if (r) begin m_c = m_q[0];   m_q = m_q >> 1; end
    else if (s) begin m_c = m_q[W-1]; m_q = m_q << 1; end
    else if (o) begin m_c = m_q[0];   m_q = {m_q[0], m_q[W-1:1]}; end
    e.q = m_q; e.c = m_c; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares after every edge that has a pending prediction
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compare(e.q, e.c, e.tag);
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #25;
    compare('0, 1'b0, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    compare('0, 1'b0, "R1 after release");

    step(1,0,0,0,0, 16'hA5A5, "R3 load A5A5");
    step(0,0,0,0,0, 16'h1234, "R2 hold ignores din");
    step(0,0,0,0,0, 16'hFFFF, "R2 hold second cycle");
    step(0,1,0,0,0, '0, "R4 asr of A5A5");
    step(0,1,0,0,0, '0, "R4 asr sign kept");
    step(1,0,0,0,0, 16'h8001, "R3 load 8001 carry kept");
    step(0,0,1,0,0, '0, "R5 lsr clears msb");
    step(0,0,1,0,0, '0, "R5 lsr again");
    step(1,0,0,0,0, 16'h8001, "R3 reload 8001");
    step(0,0,0,1,0, '0, "R6 shl msb to carry");
    step(0,0,0,1,0, '0, "R6 shl zero carry");
    step(1,0,0,0,0, 16'h0003, "R3 load 0003");
    step(0,0,0,0,1, '0, "R7 ror wraps lsb");
    step(0,0,0,0,1, '0, "R7 ror wraps again");
    step(0,0,0,0,1, '0, "R7 ror zero lsb");
    for (int i = 0; i < W; i++) step(0,0,0,1,0, '0, "R6 shl chain");
    step(1,0,0,0,0, 16'hFFFF, "R3 load ones");
    for (int i = 0; i < W + 1; i++) step(0,0,0,1,0, '0, "R6 shl drain");

    // R8: priority between simultaneous requests
    step(1,0,0,0,0, 16'h8002, "R3 setup 8002");
    step(1,1,1,1,1, 16'h7FFE, "R8 load beats all");
    step(1,0,0,0,0, 16'h8003, "R3 setup 8003");
    step(0,1,1,1,1, '0, "R8 asr beats lsr/shl/ror");
    step(0,0,1,1,1, '0, "R8 lsr beats shl/ror");
    step(1,0,0,0,0, 16'hC001, "R3 setup C001");
    step(0,0,0,1,1, '0, "R8 shl beats ror");
    step(0,0,0,0,1, '0, "R7 ror after shl");
    step(0,0,0,0,0, '0, "R2 final hold");

    @(negedge clk);
    op_load = 0; op_asr = 0; op_lsr = 0; op_shl = 0; op_ror = 0;
    @(posedge clk); #10;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule